// File: doc/BRIEF.md
# Segmented Parallel Component Table Lookup

This block expands compressed test vectors on a tester channel board. Every bit symbol of a vector is built from three component codes (drive, measure and high-impedance) and a residual value. The three component codes sit in three separate on-chip tables with 64-bit entries. Each table has its own depth.

The block works in two phases. After reset it is in download mode. Bytes arriving on a byte-wide load port are packed into 64-bit words, and an internal pointer writes those words into the drive table first, then the measure table, then the high-impedance table. When the last high-impedance entry has been written, the block raises a completion flag and switches to lookup mode.

In lookup mode it accepts a valid/ready stream of records. Each record is one combined address and one residual value. The address is cut into three indices, all three tables are read in the same cycle, and the three words leave together with the residual on a valid/ready output stream. The output stream feeds a waveform generator.

Top module: `seg_table_decoder`

## Requirements
- R1: In download mode a byte is taken on every cycle with `ld_valid` high. Eight bytes form one 64-bit entry, and the first byte lands in bits 7:0. Entries fill drive indices 0 upward, then measure indices 0 upward, then high-impedance indices 0 upward.
- R2: `load_done` rises in the cycle after the final byte of the last high-impedance entry is taken. It stays high until reset.
- R3: While `load_done` is low, `rec_ready` is low, no record is taken and `out_valid` stays low.
- R4: `rec_addr` is the concatenation {drive index, measure index, high-impedance index}, with the drive index in the most significant bits. Each field is log2 of its table depth wide; with defaults 16/8/4 these are bits 8:5, 4:2 and 1:0.
- R5: `out_drive`, `out_meas` and `out_hiz` are the loaded entries that the indices of a single record select.
- R6: `out_resid` carries the residual of the same record as the three words beside it.
- R7: A record taken at a clock edge is presented with `out_valid` high right after that edge.
- R8: While `out_valid` is high and `out_ready` is low, all outputs hold. Each taken record is delivered exactly once and in order.
- R9: After loading, `rec_ready` is high whenever `out_valid` is low or `out_ready` is high, so one record per cycle can pass.
- R10: Load bytes offered after `load_done` are ignored and leave all three tables unchanged.
- R11: A synchronous reset clears `load_done` and `out_valid` and returns the byte count and the pointer to drive entry 0.
- R12: Idle cycles between load bytes do not change how bytes are packed or where they are placed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load byte present |
| ld_byte | input | 8 | Load byte |
| load_done | output | 1 | All tables filled; lookup mode |
| rec_valid | input | 1 | Record present |
| rec_ready | output | 1 | Record taken when high with rec_valid |
| rec_addr | input | ADDR_W (9) | Combined table address |
| rec_resid | input | RES_W (16) | Residual value |
| out_valid | output | 1 | Output words present |
| out_ready | input | 1 | Downstream takes the output |
| out_drive | output | WORD_W (64) | Drive component word |
| out_meas | output | WORD_W (64) | Measure component word |
| out_hiz | output | WORD_W (64) | High-impedance component word |
| out_resid | output | RES_W (16) | Residual aligned with the words |

## Verification
The assertions assume the following about the inputs:
- `out_ready` is a free input.
- Record inputs may change at any time while `rec_ready` is low.
- Every table depth is a power of two no smaller than two, so every address field value selects a loaded entry.

The stimulus keeps to these limits by using the default power-of-two depths and by sweeping every combined address. It runs the sweep both with steady flow and with periodic gaps on `rec_valid` and `out_ready`. It also offers load bytes and records in the wrong mode, so that the gating claims are exercised rather than assumed.

// File: rtl/seg_lut_pkg.sv
package seg_lut_pkg;

  localparam int NUM_TABLES = 3;

  typedef enum logic [1:0] {
    TBL_DRIVE = 2'd0,
    TBL_MEAS  = 2'd1,
    TBL_HIZ   = 2'd2
  } tbl_sel_e;

  // index width for a table of the given depth (at least one bit)
  function automatic int idx_width(input int depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/seg_comp_ram.sv
module seg_comp_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 64,
  localparam int AW = seg_lut_pkg::idx_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // write port: no reset on storage so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read with enable; enable low holds the output word
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/seg_load_ctrl.sv
module seg_load_ctrl
  import seg_lut_pkg::*;
#(
  parameter int WORD_W    = 64,
  parameter int DRV_DEPTH = 16,
  parameter int MEA_DEPTH = 8,
  parameter int HIZ_DEPTH = 4,
  parameter int PTR_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_valid,
  input  logic [7:0]            ld_byte,
  output logic [NUM_TABLES-1:0] wr_en,
  output logic [PTR_W-1:0]      wr_idx,
  output logic [WORD_W-1:0]     wr_data,
  output logic                  load_done
);

  localparam int BYTES  = WORD_W / 8;
  localparam int BCNT_W = idx_width(BYTES);

  tbl_sel_e          tbl_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  last_idx;
  logic [BCNT_W-1:0] bcnt_q;
  logic [WORD_W-1:0] shreg_q;
  logic              done_q;
  logic              take;
  logic              word_end;

  assign take     = ld_valid && !done_q;
  assign word_end = take && (bcnt_q == BCNT_W'(BYTES - 1));
  assign wr_data  = {ld_byte, shreg_q[WORD_W-1:8]};
  assign wr_idx   = ptr_q;
  assign load_done = done_q;

  always_comb begin
    case (tbl_q)
      TBL_DRIVE: last_idx = PTR_W'(DRV_DEPTH - 1);
      TBL_MEAS:  last_idx = PTR_W'(MEA_DEPTH - 1);
      default:   last_idx = PTR_W'(HIZ_DEPTH - 1);
    endcase
  end

  for (genvar g = 0; g < NUM_TABLES; g++) begin : g_wen
    assign wr_en[g] = word_end && (tbl_q == tbl_sel_e'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_q   <= TBL_DRIVE;
      ptr_q   <= '0;
      bcnt_q  <= '0;
      shreg_q <= '0;
      done_q  <= 1'b0;
    end else if (take) begin
      // new byte enters at the top; first byte ends at the bottom
      shreg_q <= {ld_byte, shreg_q[WORD_W-1:8]};
      if (word_end) begin
        bcnt_q <= '0;
        if (ptr_q == last_idx) begin
          ptr_q <= '0;
          if (tbl_q == TBL_HIZ) done_q <= 1'b1;
          else                  tbl_q  <= tbl_sel_e'(tbl_q + 2'd1);
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end else begin
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/seg_out_ctrl.sv
module seg_out_ctrl #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_done,
  input  logic             rec_valid,
  input  logic [RES_W-1:0] rec_resid,
  input  logic             out_ready,
  output logic             rec_ready,
  output logic             rd_en,
  output logic             out_valid,
  output logic [RES_W-1:0] out_resid
);

  logic valid_q;

  // advance only when the output slot is empty or being drained
  assign rec_ready = load_done && (!valid_q || out_ready);
  assign rd_en     = rec_valid && rec_ready;
  assign out_valid = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      out_resid <= '0;
    end else if (rd_en) begin
      valid_q   <= 1'b1;
      out_resid <= rec_resid;   // one stage, matching the table read
    end else if (out_ready) begin
      valid_q   <= 1'b0;
    end
  end

endmodule

// File: rtl/seg_table_decoder.sv
module seg_table_decoder
  import seg_lut_pkg::*;
#(
  parameter int WORD_W    = 64,
  parameter int RES_W     = 16,
  parameter int DRV_DEPTH = 16,
  parameter int MEA_DEPTH = 8,
  parameter int HIZ_DEPTH = 4,
  localparam int DRV_IW = idx_width(DRV_DEPTH),
  localparam int MEA_IW = idx_width(MEA_DEPTH),
  localparam int HIZ_IW = idx_width(HIZ_DEPTH),
  localparam int ADDR_W = DRV_IW + MEA_IW + HIZ_IW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [7:0]        ld_byte,
  output logic              load_done,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [ADDR_W-1:0] rec_addr,
  input  logic [RES_W-1:0]  rec_resid,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_drive,
  output logic [WORD_W-1:0] out_meas,
  output logic [WORD_W-1:0] out_hiz,
  output logic [RES_W-1:0]  out_resid
);

  localparam int PTR_W = max3(DRV_IW, MEA_IW, HIZ_IW);

  logic [NUM_TABLES-1:0] wr_en;
  logic [PTR_W-1:0]      wr_idx;
  logic [WORD_W-1:0]     wr_data;
  logic                  rd_en;
  logic [WORD_W-1:0]     comp_word [NUM_TABLES];

  seg_load_ctrl #(
    .WORD_W   (WORD_W),
    .DRV_DEPTH(DRV_DEPTH),
    .MEA_DEPTH(MEA_DEPTH),
    .HIZ_DEPTH(HIZ_DEPTH),
    .PTR_W    (PTR_W)
  ) u_load (
    .clk      (clk),
    .rst      (rst),
    .ld_valid (ld_valid),
    .ld_byte  (ld_byte),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .load_done(load_done)
  );

  seg_out_ctrl #(
    .RES_W(RES_W)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .load_done(load_done),
    .rec_valid(rec_valid),
    .rec_resid(rec_resid),
    .out_ready(out_ready),
    .rec_ready(rec_ready),
    .rd_en    (rd_en),
    .out_valid(out_valid),
    .out_resid(out_resid)
  );

  // one table per component; field position follows the concatenation order
  for (genvar g = 0; g < NUM_TABLES; g++) begin : g_tbl
    localparam int DEP = (g == 0) ? DRV_DEPTH : (g == 1) ? MEA_DEPTH : HIZ_DEPTH;
    localparam int AW  = idx_width(DEP);
    localparam int LO  = (g == 0) ? (MEA_IW + HIZ_IW) : (g == 1) ? HIZ_IW : 0;

    seg_comp_ram #(
      .DEPTH(DEP),
      .WIDTH(WORD_W)
    ) u_ram (
      .clk  (clk),
      .rst  (rst),
      .we   (wr_en[g]),
      .waddr(wr_idx[AW-1:0]),
      .wdata(wr_data),
      .re   (rd_en),
      .raddr(rec_addr[LO +: AW]),
      .rdata(comp_word[g])
    );
  end

  assign out_drive = comp_word[0];
  assign out_meas  = comp_word[1];
  assign out_hiz   = comp_word[2];

endmodule

// File: rtl/seg_table_decoder_chk.sv
module seg_table_decoder_chk #(
  parameter int WORD_W = 64,
  parameter int RES_W  = 16,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_valid,
  input logic              load_done,
  input logic              rec_valid,
  input logic              rec_ready,
  input logic [ADDR_W-1:0] rec_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_drive,
  input logic [WORD_W-1:0] out_meas,
  input logic [WORD_W-1:0] out_hiz,
  input logic [RES_W-1:0]  out_resid
);

  // R2: completion flag is sticky until reset
  a_r2_done_sticky: assert property (@(posedge clk) disable iff (rst)
    load_done |=> load_done);

  // R3: no record taken before loading completes
  a_r3_no_early_ready: assert property (@(posedge clk) disable iff (rst)
    !load_done |-> !rec_ready);

  // R3: output stays empty while loading
  a_r3_no_early_output: assert property (@(posedge clk) disable iff (rst)
    !load_done |=> !out_valid);

  // R7: taken record shows up after one edge
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_ready) |=> out_valid);

  // R8: stalled output holds every field
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable({out_drive, out_meas, out_hiz, out_resid})));

  // R8: drained output without a new record empties
  a_r8_no_dup: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !(rec_valid && rec_ready)) |=> !out_valid);

  // R9: free output slot means ready after loading
  a_r9_throughput: assert property (@(posedge clk) disable iff (rst)
    (load_done && (!out_valid || out_ready)) |-> rec_ready);

  // R11: synchronous reset clears mode and output
  a_r11_reset: assert property (@(posedge clk)
    rst |=> (!load_done && !out_valid));

endmodule

bind seg_table_decoder seg_table_decoder_chk #(
  .WORD_W(WORD_W),
  .RES_W (RES_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ld_valid (ld_valid),
  .load_done(load_done),
  .rec_valid(rec_valid),
  .rec_ready(rec_ready),
  .rec_addr (rec_addr),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_drive(out_drive),
  .out_meas (out_meas),
  .out_hiz  (out_hiz),
  .out_resid(out_resid)
);

// File: tb/seg_table_decoder_test.sv
`timescale 1ns/1ps
module seg_table_decoder_test;

  localparam int WORD_W = 64;
  localparam int RES_W  = 16;
  localparam int DD = 16;
  localparam int MD = 8;
  localparam int HD = 4;
  localparam int DW = 4;
  localparam int MW = 3;
  localparam int HW = 2;
  localparam int AW = DW + MW + HW;
  localparam int NADDR = 1 << AW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ld_valid = 1'b0;
  logic [7:0]        ld_byte = '0;
  logic              load_done;
  logic              rec_valid = 1'b0;
  logic              rec_ready;
  logic [AW-1:0]     rec_addr = '0;
  logic [RES_W-1:0]  rec_resid = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [WORD_W-1:0] out_drive, out_meas, out_hiz;
  logic [RES_W-1:0]  out_resid;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  seg_table_decoder uut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_byte(ld_byte),
    .load_done(load_done), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_addr(rec_addr), .rec_resid(rec_resid), .out_valid(out_valid),
    .out_ready(out_ready), .out_drive(out_drive), .out_meas(out_meas),
    .out_hiz(out_hiz), .out_resid(out_resid)
  );

  function automatic logic [7:0] bval(int seed, int t, int i, int k);
    return 8'((seed * 29 + t * 71 + i * 13 + k * 7 + i * i) & 255);
  endfunction

  function automatic logic [63:0] wval(int seed, int t, int i);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[k*8 +: 8] = bval(seed, t, i, k);
    return w;
  endfunction

  function automatic int depth_of(int t);
    return (t == 0) ? DD : (t == 1) ? MD : HD;
  endfunction

  function automatic logic [RES_W-1:0] rval(int seed, int a);
    return RES_W'(a * 97 + seed * 5 + 3);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_byte  = b;
    @(negedge clk);
    ld_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // full table download; records offered meanwhile must be refused (R3)
  task automatic load_all(input int seed);
    rec_valid = 1'b1;
    out_ready = 1'b1;
    for (int t = 0; t < 3; t++) begin
      for (int i = 0; i < depth_of(t); i++) begin
        for (int k = 0; k < 8; k++) begin
          if (t == 2 && i == HD - 1 && k == 7) begin
            @(negedge clk);
            check(load_done == 1'b0, "R2 early done", 64'(load_done), 64'd0);
            check(rec_ready == 1'b0 && out_valid == 1'b0, "R3 gated during load",
                  64'({rec_ready, out_valid}), 64'd0);
          end
          // R12: irregular gaps between bytes
          send_byte(bval(seed, t, i, k), (i + k) % 3);
        end
      end
    end
    rec_valid = 1'b0;
    @(negedge clk);
    check(load_done == 1'b1, "R2 done after last byte", 64'(load_done), 64'd1);
  endtask

  // sweep every combined address; mode 1 adds gaps and stalls
  task automatic run_lookups(input int seed, input int mode);
    int q[$];
    int next = 0;
    int cyc = 0;
    bit held = 1'b0;
    logic [63:0] hd = '0;
    logic [RES_W-1:0] hr = '0;
    while (next < NADDR || q.size() > 0) begin
      @(negedge clk);
      if (held) begin
        check(out_valid && out_drive == hd && out_resid == hr, "R8 hold on stall",
              out_drive, hd);
      end
      if (out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R8 extra output", 64'(out_resid), 64'd0);
        end else begin
          int a = q[0];
          int di = a >> (MW + HW);
          int mi = (a >> HW) & (MD - 1);
          int zi = a & (HD - 1);
          check(out_drive == wval(seed, 0, di), "R4 R5 drive word", out_drive,
                wval(seed, 0, di));
          check(out_meas == wval(seed, 1, mi), "R4 R5 measure word", out_meas,
                wval(seed, 1, mi));
          check(out_hiz == wval(seed, 2, zi), "R4 R5 hiz word", out_hiz,
                wval(seed, 2, zi));
          check(out_resid == rval(seed, a), "R6 residual aligned", 64'(out_resid),
                64'(rval(seed, a)));
        end
      end else if (q.size() > 0) begin
        check(1'b0, "R7 missing output", 64'(out_valid), 64'd1);
      end
      rec_valid = (next < NADDR) && (mode == 0 || (cyc % 5) != 2);
      rec_addr  = AW'(next);
      rec_resid = rval(seed, next);
      out_ready = (mode == 0) || ((cyc % 3) != 0);
      #1;
      check(rec_ready == (!out_valid || out_ready), "R9 ready rule",
            64'(rec_ready), 64'(!out_valid || out_ready));
      held = out_valid && !out_ready;
      hd = out_drive;
      hr = out_resid;
      if (out_valid && out_ready && q.size() > 0) void'(q.pop_front());
      if (rec_valid && rec_ready) begin
        q.push_back(next);
        next++;
      end
      cyc++;
    end
    @(negedge clk);
    rec_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(load_done == 1'b0 && out_valid == 1'b0 && rec_ready == 1'b0,
          "R11 reset state", 64'({load_done, out_valid, rec_ready}), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(load_done == 1'b0 && out_valid == 1'b0 && rec_ready == 1'b0,
          "R11 initial reset state", 64'({load_done, out_valid, rec_ready}), 64'd0);

    load_all(1);                  // R1 R2 R3 R12
    run_lookups(1, 0);            // R4 R5 R6 R7 R9

    // R10: extra bytes after completion must not touch the tables
    for (int n = 0; n < 24; n++) send_byte(8'hFF, 0);
    check(load_done == 1'b1, "R10 still done", 64'(load_done), 64'd1);
    run_lookups(1, 1);            // R8 R10 with stalls

    // R11: reset mid-word, then reset again; reload must start at drive entry 0
    do_reset();
    send_byte(8'h5A, 0);
    send_byte(8'hC3, 1);
    send_byte(8'h11, 0);
    do_reset();
    load_all(2);
    run_lookups(2, 1);            // R1 R11 via new contents

    // reset while output is occupied
    @(negedge clk);
    rec_valid = 1'b1;
    rec_addr  = '0;
    out_ready = 1'b0;
    @(negedge clk);
    rec_valid = 1'b0;
    check(out_valid == 1'b1, "R7 occupied before reset", 64'(out_valid), 64'd1);
    do_reset();

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule